// File: doc/BRIEF.md
# Clock Recovery Rate Search Sequencer

This block is the slow control engine of a clock recovery loop that has to find the rate of an incoming serial stream. It runs on a low-frequency system clock that has no relation to the data. The block holds a 3-bit rate code. It turns that code into a divider modulus and an oscillator band for the loop. For each setting it runs one acquisition cycle: an upward frequency sweep, then a downward sweep, then a single idle tick. It keeps doing this until the loop reports lock.

In automatic mode, an internal counter steps through the codes 0 to 4 and wraps back to 0. The code is driven out with its output enable asserted. In manual mode, the output enable drops and the code comes from an external input. Every cycle then uses that fixed setting. Two decode sets are available, chosen by a set-select input:
- The five-setting set alternates low and high bands.
- The three-moduli set uses the high band only and repeats moduli 4 and 2 on two codes each.

The lock flag passes through a two-flop synchronizer before it is used. Lock freezes the search. Losing lock restarts the search with an upward sweep on the same code.

Top module: `rate_search_seq`

## Requirements
- R1: In automatic mode (auto_mode=1), code_oe is 1 and code_out carries the search code. In manual mode, code_oe is 0 and the decoded setting follows code_in.
- R2: With set_sel=1, the codes decode as follows. div_mod is the modulus as a binary number, and band_hi=1 means the high band.

  | Code | div_mod | Band |
  |------|---------|------|
  | 0 | 4 | high |
  | 1 | 2 | low |
  | 2 | 2 | high |
  | 3 | 1 | low |
  | 4 | 1 | high |

- R3: With set_sel=0, codes 0 and 1 give div_mod=4, codes 2 and 3 give div_mod=2, and code 4 gives div_mod=1. All of them use the high band. Codes 5 to 7 give div_mod=0 and band_hi=0 in both sets.
- R4: Each acquisition cycle has three parts:
  - L ticks with sweep_up=1 and sweep_act=1;
  - then L ticks with sweep_up=0 and sweep_act=1;
  - then one tick with sweep_act=0.

  L is phase_len, and a phase_len of 0 counts as 1.
- R5: In automatic mode, the code advances by one when a cycle ends without lock. It wraps from 4 to 0 and never shows 5, 6 or 7.
- R6: lock_in is synchronized through two flops. On the third rising clock edge after lock_in rises, sweep_act goes low. The code stays frozen while lock is held.
- R7: On the third rising edge after lock_in falls, acquisition restarts with a full upward sweep on the unchanged code.
- R8: In manual mode, a code_in of 5, 6 or 7 raises code_bad and forces sweep_act low at once. When a valid code returns, the next cycle starts with an upward sweep.
- R9: Reset release goes through a two-flop synchronizer. After reset the search code is 0, the upward sweep is active, and code_bad is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = automatic search, 0 = manual code |
| set_sel | input | 1 | 1 = five-setting decode set, 0 = three-moduli set |
| code_in | input | 3 | Rate code used in manual mode |
| lock_in | input | 1 | Asynchronous lock indication from the loop |
| phase_len | input | CNT_W | Ticks per sweep direction |
| code_out | output | 3 | Search code, meaningful when code_oe is 1 |
| code_oe | output | 1 | Output enable for code_out |
| div_mod | output | 3 | Divider modulus (4, 2, 1, or 0 if unused) |
| band_hi | output | 1 | Oscillator band, 1 = high |
| sweep_up | output | 1 | Sweep direction, 1 = upward |
| sweep_act | output | 1 | Sweep running |
| code_bad | output | 1 | Manual code is unused |

## Verification
The hardest situations to reach from the ports are these:
- a lock or a mode change that lands exactly on the single idle tick between cycles, where the code would otherwise advance;
- a phase length that shrinks while a sweep phase is already past its new end.

The stimulus uses short phase lengths (0 to 4 ticks), so that idle ticks are frequent. It toggles lock, mode, set and phase length at random over tens of thousands of cycles. A cycle-level reference model built from the requirements checks every tick. Directed sequences cover reset, the 4-to-0 wrap, lock timing and invalid manual codes.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned LAST_CODE = 4;

  typedef enum logic [2:0] {
    ST_UP   = 3'd0,
    ST_DOWN = 3'd1,
    ST_GAP  = 3'd2,
    ST_LOCK = 3'd3,
    ST_HALT = 3'd4
  } sweep_state_e;
endpackage

// File: rtl/rss_sync.sv
module rss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rss_rate_decode.sv
module rss_rate_decode
  import rss_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              set_sel,
  output logic [2:0]        div_mod,
  output logic              band_hi,
  output logic              valid
);
  always_comb begin
    div_mod = 3'd0;
    band_hi = 1'b0;
    valid   = (code <= CODE_W'(LAST_CODE));
    if (set_sel) begin
      case (code)
        3'd0: begin div_mod = 3'd4; band_hi = 1'b1; end
        3'd1: begin div_mod = 3'd2; band_hi = 1'b0; end
        3'd2: begin div_mod = 3'd2; band_hi = 1'b1; end
        3'd3: begin div_mod = 3'd1; band_hi = 1'b0; end
        3'd4: begin div_mod = 3'd1; band_hi = 1'b1; end
        default: begin div_mod = 3'd0; band_hi = 1'b0; end
      endcase
    end else begin
      case (code)
        3'd0, 3'd1: begin div_mod = 3'd4; band_hi = 1'b1; end
        3'd2, 3'd3: begin div_mod = 3'd2; band_hi = 1'b1; end
        3'd4:       begin div_mod = 3'd1; band_hi = 1'b1; end
        default:    begin div_mod = 3'd0; band_hi = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/rss_sweep_fsm.sv
module rss_sweep_fsm
  import rss_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_mode,
  input  logic              code_bad,
  input  logic              lock_s,
  input  logic [CNT_W-1:0]  phase_len,
  output logic [CODE_W-1:0] rate_q,
  output sweep_state_e      st_q
);
  sweep_state_e      st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] rate_d;
  logic [CNT_W-1:0]  phase_last;
  logic              phase_end;
  logic              advance;
  logic              rate_en;

  always_comb begin
    phase_last = (phase_len == '0) ? '0 : phase_len - CNT_W'(1);
    phase_end  = (cnt_q >= phase_last);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (code_bad) begin
      st_d  = ST_HALT;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_HALT: begin
          st_d  = ST_UP;
          cnt_d = '0;
        end
        ST_LOCK: begin
          if (!lock_s) begin
            st_d  = ST_UP;
            cnt_d = '0;
          end
        end
        default: begin
          if (lock_s) begin
            st_d  = ST_LOCK;
            cnt_d = '0;
          end else begin
            case (st_q)
              ST_UP: begin
                if (phase_end) begin
                  st_d  = ST_DOWN;
                  cnt_d = '0;
                end else begin
                  cnt_d = cnt_q + CNT_W'(1);
                end
              end
              ST_DOWN: begin
                if (phase_end) begin
                  st_d  = ST_GAP;
                  cnt_d = '0;
                end else begin
                  cnt_d = cnt_q + CNT_W'(1);
                end
              end
              default: begin
                st_d  = ST_UP;
                cnt_d = '0;
              end
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    advance = auto_mode && (st_q == ST_GAP) && !code_bad && !lock_s;
    rate_en = advance;
    rate_d  = (rate_q == CODE_W'(LAST_CODE)) ? '0 : rate_q + CODE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_UP;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (rate_en) begin
      rate_q <= rate_d;
    end
  end

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q <= CODE_W'(LAST_CODE));

  // R4
  gap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |=> (st_q != ST_GAP));

  // R4
  up_to_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UP && !code_bad && !lock_s && phase_end) |=> (st_q == ST_DOWN));

  // R6
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |=> $stable(rate_q));

  // R7
  relock_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && !lock_s && !code_bad) |=> (st_q == ST_UP && cnt_q == '0));
endmodule

// File: rtl/rate_search_seq.sv
module rate_search_seq
  import rss_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic             set_sel,
  input  logic [2:0]       code_in,
  input  logic             lock_in,
  input  logic [CNT_W-1:0] phase_len,
  output logic [2:0]       code_out,
  output logic             code_oe,
  output logic [2:0]       div_mod,
  output logic             band_hi,
  output logic             sweep_up,
  output logic             sweep_act,
  output logic             code_bad
);
  logic              rst_n_i;
  logic              lock_s;
  logic [CODE_W-1:0] rate_q;
  logic [CODE_W-1:0] code_sel;
  logic              code_ok;
  sweep_state_e      st_q;

  rss_sync #(.STAGES(SYNC_STGS)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_i)
  );

  rss_sync #(.STAGES(SYNC_STGS)) u_lock_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (lock_in),
    .q     (lock_s)
  );

  always_comb begin
    code_sel = auto_mode ? rate_q : code_in;
  end

  rss_rate_decode u_dec (
    .code    (code_sel),
    .set_sel (set_sel),
    .div_mod (div_mod),
    .band_hi (band_hi),
    .valid   (code_ok)
  );

  always_comb begin
    code_bad = !auto_mode && !code_ok;
  end

  rss_sweep_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .auto_mode (auto_mode),
    .code_bad  (code_bad),
    .lock_s    (lock_s),
    .phase_len (phase_len),
    .rate_q    (rate_q),
    .st_q      (st_q)
  );

  always_comb begin
    code_out  = rate_q;
    code_oe   = auto_mode;
    sweep_act = ((st_q == ST_UP) || (st_q == ST_DOWN)) && !code_bad;
    sweep_up  = (st_q == ST_UP) && !code_bad;
  end

  // R8
  bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    code_bad |-> (!sweep_act && div_mod == 3'd0));

  // R1
  manual_oe_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !auto_mode |-> !code_oe);
endmodule

// File: tb/rate_search_seq_test.sv
module rate_search_seq_test;
  localparam int CNT_W = 16;
  localparam int UP = 0, DN = 1, GAP = 2, LCK = 3, HLT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic auto_mode, set_sel, lock_in;
  logic [2:0] code_in;
  logic [CNT_W-1:0] phase_len;
  logic [2:0] code_out, div_mod;
  logic code_oe, band_hi, sweep_up, sweep_act, code_bad;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rate_search_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .set_sel(set_sel),
    .code_in(code_in), .lock_in(lock_in), .phase_len(phase_len),
    .code_out(code_out), .code_oe(code_oe), .div_mod(div_mod),
    .band_hi(band_hi), .sweep_up(sweep_up), .sweep_act(sweep_act),
    .code_bad(code_bad)
  );

  // Reference model written from the requirements
  logic mr1, mr2, ml1, ml2;
  int   ms, mc;
  int   mq;

  function automatic int exp_div(input int code, input bit s);
    if (code > 4) return 0;
    if (s) return (code == 0) ? 4 : (code <= 2) ? 2 : 1;
    return (code <= 1) ? 4 : (code <= 3) ? 2 : 1;
  endfunction

  function automatic int exp_band(input int code, input bit s);
    if (code > 4) return 0;
    if (s) return (code == 1 || code == 3) ? 0 : 1;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 0; mr2 <= 0; ml1 <= 0; ml2 <= 0; ms <= UP; mc <= 0; mq <= 0;
    end else begin
      mr1 <= 1'b1;
      mr2 <= mr1;
      if (!mr2) begin
        ml1 <= 0; ml2 <= 0; ms <= UP; mc <= 0; mq <= 0;
      end else begin
        automatic int len  = (phase_len == 0) ? 1 : int'(phase_len);
        automatic bit bad  = !auto_mode && code_in > 3'd4;
        ml1 <= lock_in;
        ml2 <= ml1;
        if (bad) begin ms <= HLT; mc <= 0; end
        else if (ms == HLT) begin ms <= UP; mc <= 0; end
        else if (ms == LCK) begin if (!ml2) begin ms <= UP; mc <= 0; end end
        else if (ml2) begin ms <= LCK; mc <= 0; end
        else if (ms == UP) begin
          if (mc >= len - 1) begin ms <= DN; mc <= 0; end else mc <= mc + 1;
        end else if (ms == DN) begin
          if (mc >= len - 1) begin ms <= GAP; mc <= 0; end else mc <= mc + 1;
        end else begin
          ms <= UP; mc <= 0;
          if (auto_mode) mq <= (mq == 4) ? 0 : mq + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    automatic int  code = auto_mode ? mq : int'(code_in);
    automatic bit  bad  = !auto_mode && code_in > 3'd4;
    automatic bit  act  = (ms == UP || ms == DN) && !bad;
    chk(code_oe == auto_mode, "R1 code_oe", code_oe, auto_mode);
    if (auto_mode) chk(int'(code_out) == mq, "R5 code_out", code_out, mq);
    if (set_sel) chk(int'(div_mod) == exp_div(code, 1), "R2 div_mod", div_mod, exp_div(code, 1));
    else         chk(int'(div_mod) == exp_div(code, 0), "R3 div_mod", div_mod, exp_div(code, 0));
    chk(int'(band_hi) == exp_band(code, set_sel), "R2 R3 band_hi", band_hi, exp_band(code, set_sel));
    chk(sweep_act == act, "R4 R6 R7 sweep_act", sweep_act, act);
    chk(sweep_up == (act && ms == UP), "R4 sweep_up", sweep_up, act && ms == UP);
    chk(code_bad == bad, "R8 code_bad", code_bad, bad);
  endtask

  int prev_code = 0;
  bit prev_auto = 0;

  task automatic tick_check();
    @(negedge clk);
    compare_all();
    if (auto_mode && prev_auto) begin
      chk(code_out <= 3'd4, "R5 range", code_out, 4);
      if (prev_code == 4 && code_out != 3'd4)
        chk(code_out == 3'd0, "R5 wrap", code_out, 0);
    end
    prev_code = code_out;
    prev_auto = auto_mode;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; auto_mode = 1; set_sel = 1; code_in = 0; lock_in = 0; phase_len = 2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(code_out == 3'd0, "R9 code", code_out, 0);
    chk(sweep_up && sweep_act, "R9 sweep_up", sweep_up, 1);
    chk(!code_bad, "R9 code_bad", code_bad, 0);

    // Directed full pass over all five codes, with a wrap
    repeat (40) tick_check();

    // R6 lock: wait for it to propagate and freeze
    lock_in = 1;
    repeat (4) tick_check();
    begin
      automatic logic [2:0] held = code_out;
      chk(!sweep_act, "R6 stopped", sweep_act, 0);
      repeat (12) tick_check();
      chk(code_out == held, "R6 frozen", code_out, held);
      // R7 restart on the same code with an up sweep
      lock_in = 0;
      repeat (3) tick_check();
      chk(sweep_up && code_out == held, "R7 restart", sweep_up, 1);
    end

    // R8 invalid manual code, seen at once
    auto_mode = 0; code_in = 3'd6;
    #1;
    chk(code_bad && !sweep_act, "R8 bad", code_bad, 1);
    repeat (3) tick_check();
    code_in = 3'd2;
    repeat (2) tick_check();
    chk(sweep_up, "R8 resume", sweep_up, 1);

    // Phase length 0 behaves as 1 (R4)
    auto_mode = 1; phase_len = 0;
    repeat (20) tick_check();

    // Random mix
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if ($urandom_range(299) == 0) auto_mode = ~auto_mode;
      if ($urandom_range(149) == 0) set_sel = ~set_sel;
      if ($urandom_range(39) == 0) code_in = 3'($urandom_range(7));
      if ($urandom_range(199) == 0) lock_in = ~lock_in;
      if ($urandom_range(499) == 0) phase_len = CNT_W'($urandom_range(4));
      tick_check();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule